// File: doc/BRIEF.md
# Priority Multi-Field Header Rule Matcher

This block sorts one packet header into a flow by checking it against a small on-chip table of classification rules and reporting the single best rule that fits. A header carries a 32-bit source address, a 32-bit destination address, a 16-bit source port, a 16-bit destination port and an 8-bit protocol number. Every rule constrains all five of them. The two addresses are matched as prefixes of a given length. Each port is tested for equality, tested for being strictly greater than a value, or left free. The protocol is either an exact value or free.

Rules are loaded one at a time through a write port that addresses a table slot. A lookup request samples the header and compares it against every slot in parallel. One clock later the block returns a hit flag and the slot number of the winning rule. Rule priority follows slot position: slot 0 beats every other slot. The block does no hashing and uses no external memory.

Top module: `pkt_rule_matcher`

## Requirements
- R1: Reset clears every table slot to invalid and drives rspValid, rspHit and rspIdx to 0.
- R2: rspValid is 1 exactly in the cycle after a cycle with reqValid high, and 0 otherwise.
- R3: An address field matches when the top L bits of header and rule prefix agree, L being the rule's 6-bit length. L=0 matches any address, and any L of 32 or more compares all 32 bits.
- R4: Port operation codes are 2'b00 any value, 2'b01 header port equal to rule port, 2'b10 header port strictly greater than rule port, and 2'b11 never matches.
- R5: With the protocol-free flag set, any protocol matches. With it clear, the header protocol must equal the rule protocol.
- R6: A rule hits only when all five field tests pass together.
- R7: A slot written with its valid bit at 0 never hits, whatever its fields hold.
- R8: When several slots hit, rspIdx reports the lowest-numbered one.
- R9: When no slot hits, rspHit is 0 and rspIdx is 0.
- R10: A rule written in the same cycle as a request does not affect that request. It is seen by the next request one cycle later.
- R11: rspHit and rspIdx hold their last values in cycles with no request result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Load a rule into slot wrIdx |
| wrIdx | input | 4 | Table slot to load |
| wrValid | input | 1 | Valid bit of the loaded rule |
| wrSrcPfx | input | 32 | Source address prefix |
| wrSrcLen | input | 6 | Source prefix length |
| wrDstPfx | input | 32 | Destination address prefix |
| wrDstLen | input | 6 | Destination prefix length |
| wrSrcOp | input | 2 | Source port operation code |
| wrSrcPort | input | 16 | Source port operand |
| wrDstOp | input | 2 | Destination port operation code |
| wrDstPort | input | 16 | Destination port operand |
| wrProtoAny | input | 1 | Protocol-free flag |
| wrProto | input | 8 | Protocol value |
| reqValid | input | 1 | Start a lookup with the header below |
| hdrSrcIp | input | 32 | Header source address |
| hdrDstIp | input | 32 | Header destination address |
| hdrSrcPort | input | 16 | Header source port |
| hdrDstPort | input | 16 | Header destination port |
| hdrProto | input | 8 | Header protocol |
| rspValid | output | 1 | Lookup result present |
| rspHit | output | 1 | At least one rule hit |
| rspIdx | output | 4 | Winning slot number |

## Verification
One rule is swept through every prefix length from 0 to 33. For each length, the header differs from the prefix in one bit at each of the 32 positions. This separates off-by-one mask errors from errors at the L=0 and L>=32 limits. Port operands are probed at the value, one below it, one above it and at both extremes under all four operation codes, which tells equal from greater-or-equal and strict greater. Overlapping wildcard rules, valid and invalid, show the priority order and the valid-bit gating. A long pseudo-random series of rule rewrites and headers drawn from small value sets then compares each result with an arithmetic model. A write issued in the same cycle as a request checks the table update ordering.

// File: rtl/rule_match_pkg.sv
package rule_match_pkg;
  parameter int ADDR_W  = 32;
  parameter int PORT_W  = 16;
  parameter int PROTO_W = 8;
  parameter int LEN_W   = 6;

  typedef enum logic [1:0] {
    PORT_ANY  = 2'b00,
    PORT_EQ   = 2'b01,
    PORT_GT   = 2'b10,
    PORT_NONE = 2'b11
  } portOp_e;

  typedef struct packed {
    logic               valid;
    logic [ADDR_W-1:0]  srcPfx;
    logic [LEN_W-1:0]   srcLen;
    logic [ADDR_W-1:0]  dstPfx;
    logic [LEN_W-1:0]   dstLen;
    portOp_e            srcOp;
    logic [PORT_W-1:0]  srcPort;
    portOp_e            dstOp;
    logic [PORT_W-1:0]  dstPort;
    logic               protoAny;
    logic [PROTO_W-1:0] proto;
  } ruleEntry_t;

  typedef struct packed {
    logic [ADDR_W-1:0]  srcIp;
    logic [ADDR_W-1:0]  dstIp;
    logic [PORT_W-1:0]  srcPort;
    logic [PORT_W-1:0]  dstPort;
    logic [PROTO_W-1:0] proto;
  } pktHdr_t;

  typedef struct packed {
    logic loadRule;
    logic startLookup;
  } ctrlStrobes_t;

  function automatic logic prefixHit(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] pfx,
                                     input logic [LEN_W-1:0]  len);
    logic [ADDR_W-1:0] mask;
    if (len >= LEN_W'(ADDR_W)) mask = '1;
    else                       mask = ~({ADDR_W{1'b1}} >> len);
    return ((addr ^ pfx) & mask) == '0;
  endfunction

  function automatic logic portHit(input portOp_e op,
                                   input logic [PORT_W-1:0] hdrPort,
                                   input logic [PORT_W-1:0] rulePort);
    case (op)
      PORT_ANY: return 1'b1;
      PORT_EQ:  return hdrPort == rulePort;
      PORT_GT:  return hdrPort > rulePort;
      default:  return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rule_ctrl.sv
module rule_ctrl
  import rule_match_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         reqValid,
  output ctrlStrobes_t strobes,
  output logic         rspValid
);
  always_comb begin
    strobes.loadRule    = wrEn;
    strobes.startLookup = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end
endmodule

// File: rtl/rule_cmp.sv
module rule_cmp
  import rule_match_pkg::*;
(
  input  ruleEntry_t rule,
  input  pktHdr_t    hdr,
  output logic       hit
);
  logic srcOk, dstOk, sPortOk, dPortOk, protoOk;

  always_comb begin
    srcOk   = prefixHit(hdr.srcIp, rule.srcPfx, rule.srcLen);
    dstOk   = prefixHit(hdr.dstIp, rule.dstPfx, rule.dstLen);
    sPortOk = portHit(rule.srcOp, hdr.srcPort, rule.srcPort);
    dPortOk = portHit(rule.dstOp, hdr.dstPort, rule.dstPort);
    protoOk = rule.protoAny || (hdr.proto == rule.proto);
    hit     = rule.valid && srcOk && dstOk && sPortOk && dPortOk && protoOk;
  end
endmodule

// File: rtl/rule_datapath.sv
module rule_datapath
  import rule_match_pkg::*;
#(
  parameter int NUM_RULES = 16,
  localparam int IDX_W = $clog2(NUM_RULES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [IDX_W-1:0] wrIdx,
  input  ruleEntry_t       wrRule,
  input  pktHdr_t          hdr,
  output logic             rspHit,
  output logic [IDX_W-1:0] rspIdx
);
  ruleEntry_t           ruleTab [NUM_RULES];
  logic [NUM_RULES-1:0] hitVec;
  logic                 anyHit;
  logic [IDX_W-1:0]     bestIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RULES; i++) ruleTab[i] <= '0;
    end else if (strobes.loadRule) begin
      ruleTab[wrIdx] <= wrRule;
    end
  end

  for (genvar g = 0; g < NUM_RULES; g++) begin : gCmp
    rule_cmp uCmp (
      .rule (ruleTab[g]),
      .hdr  (hdr),
      .hit  (hitVec[g])
    );
  end

  always_comb begin
    anyHit  = 1'b0;
    bestIdx = '0;
    for (int i = NUM_RULES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit  = 1'b1;
        bestIdx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHit <= 1'b0;
      rspIdx <= '0;
    end else if (strobes.startLookup) begin
      rspHit <= anyHit;
      rspIdx <= bestIdx;
    end
  end
endmodule

// File: rtl/pkt_rule_matcher.sv
module pkt_rule_matcher
  import rule_match_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [3:0]   wrIdx,
  input  logic         wrValid,
  input  logic [31:0]  wrSrcPfx,
  input  logic [5:0]   wrSrcLen,
  input  logic [31:0]  wrDstPfx,
  input  logic [5:0]   wrDstLen,
  input  logic [1:0]   wrSrcOp,
  input  logic [15:0]  wrSrcPort,
  input  logic [1:0]   wrDstOp,
  input  logic [15:0]  wrDstPort,
  input  logic         wrProtoAny,
  input  logic [7:0]   wrProto,
  input  logic         reqValid,
  input  logic [31:0]  hdrSrcIp,
  input  logic [31:0]  hdrDstIp,
  input  logic [15:0]  hdrSrcPort,
  input  logic [15:0]  hdrDstPort,
  input  logic [7:0]   hdrProto,
  output logic         rspValid,
  output logic         rspHit,
  output logic [3:0]   rspIdx
);
  localparam int NUM_RULES = 16;

  ctrlStrobes_t strobes;
  ruleEntry_t   wrRule;
  pktHdr_t      hdr;

  always_comb begin
    wrRule.valid    = wrValid;
    wrRule.srcPfx   = wrSrcPfx;
    wrRule.srcLen   = wrSrcLen;
    wrRule.dstPfx   = wrDstPfx;
    wrRule.dstLen   = wrDstLen;
    wrRule.srcOp    = portOp_e'(wrSrcOp);
    wrRule.srcPort  = wrSrcPort;
    wrRule.dstOp    = portOp_e'(wrDstOp);
    wrRule.dstPort  = wrDstPort;
    wrRule.protoAny = wrProtoAny;
    wrRule.proto    = wrProto;
    hdr.srcIp       = hdrSrcIp;
    hdr.dstIp       = hdrDstIp;
    hdr.srcPort     = hdrSrcPort;
    hdr.dstPort     = hdrDstPort;
    hdr.proto       = hdrProto;
  end

  rule_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .reqValid (reqValid),
    .strobes  (strobes),
    .rspValid (rspValid)
  );

  rule_datapath #(.NUM_RULES(NUM_RULES)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrIdx   (wrIdx),
    .wrRule  (wrRule),
    .hdr     (hdr),
    .rspHit  (rspHit),
    .rspIdx  (rspIdx)
  );
endmodule

// File: rtl/rule_match_chk.sv
module rule_match_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       rspValid,
  input logic       rspHit,
  input logic [3:0] rspIdx
);
  assert_rsp_after_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  assert_miss_idx_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspHit) |-> (rspIdx == 4'd0));

  assert_hold_result_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(rspHit) && $stable(rspIdx)));
endmodule

bind pkt_rule_matcher rule_match_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .rspValid (rspValid),
  .rspHit   (rspHit),
  .rspIdx   (rspIdx)
);

// File: tb/sim_pkt_rule_matcher.sv
`timescale 1ns/1ps
module sim_pkt_rule_matcher;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 0, wrValid = 0, wrProtoAny = 0, reqValid = 0;
  logic [3:0] wrIdx = 0;
  logic [31:0] wrSrcPfx = 0, wrDstPfx = 0, hdrSrcIp = 0, hdrDstIp = 0;
  logic [5:0] wrSrcLen = 0, wrDstLen = 0;
  logic [1:0] wrSrcOp = 0, wrDstOp = 0;
  logic [15:0] wrSrcPort = 0, wrDstPort = 0, hdrSrcPort = 0, hdrDstPort = 0;
  logic [7:0] wrProto = 0, hdrProto = 0;
  logic rspValid, rspHit;
  logic [3:0] rspIdx;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pkt_rule_matcher u0 (.*);

  // bench-side copy of what has been written
  bit          mValid [16];
  logic [31:0] mSrcPfx [16], mDstPfx [16];
  int          mSrcLen [16], mDstLen [16];
  int          mSrcOp [16], mDstOp [16];
  int          mSrcPort [16], mDstPort [16];
  bit          mAny [16];
  int          mProto [16];

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pfxOk(input logic [31:0] a, input logic [31:0] p, input int len);
    int l = (len > 32) ? 32 : len;
    if (l == 0) return 1;
    return (a >> (32 - l)) == (p >> (32 - l));
  endfunction

  function automatic bit portOk(input int op, input int h, input int v);
    if (op == 0) return 1;
    if (op == 1) return h == v;
    if (op == 2) return h > v;
    return 0;
  endfunction

  task automatic model(input logic [31:0] sIp, input logic [31:0] dIp, input int sP,
                       input int dP, input int pr, output bit hit, output int idx);
    hit = 0; idx = 0;
    for (int r = 0; r < 16; r++) begin
      if (!hit && mValid[r] && pfxOk(sIp, mSrcPfx[r], mSrcLen[r]) &&
          pfxOk(dIp, mDstPfx[r], mDstLen[r]) && portOk(mSrcOp[r], sP, mSrcPort[r]) &&
          portOk(mDstOp[r], dP, mDstPort[r]) && (mAny[r] || mProto[r] == pr)) begin
        hit = 1; idx = r;
      end
    end
  endtask

  task automatic setWr(input int idx, input bit v, input logic [31:0] sp, input int sl,
                       input logic [31:0] dp, input int dl, input int so, input int sv,
                       input int dO, input int dv, input bit any, input int pr);
    wrIdx = idx[3:0]; wrValid = v; wrSrcPfx = sp; wrSrcLen = sl[5:0]; wrDstPfx = dp;
    wrDstLen = dl[5:0]; wrSrcOp = so[1:0]; wrSrcPort = sv[15:0]; wrDstOp = dO[1:0];
    wrDstPort = dv[15:0]; wrProtoAny = any; wrProto = pr[7:0];
  endtask

  task automatic commitModel();
    mValid[wrIdx] = wrValid; mSrcPfx[wrIdx] = wrSrcPfx; mSrcLen[wrIdx] = wrSrcLen;
    mDstPfx[wrIdx] = wrDstPfx; mDstLen[wrIdx] = wrDstLen; mSrcOp[wrIdx] = wrSrcOp;
    mSrcPort[wrIdx] = wrSrcPort; mDstOp[wrIdx] = wrDstOp; mDstPort[wrIdx] = wrDstPort;
    mAny[wrIdx] = wrProtoAny; mProto[wrIdx] = wrProto;
  endtask

  task automatic writeRule(input int idx, input bit v, input logic [31:0] sp, input int sl,
                           input logic [31:0] dp, input int dl, input int so, input int sv,
                           input int dO, input int dv, input bit any, input int pr);
    @(negedge clk);
    setWr(idx, v, sp, sl, dp, dl, so, sv, dO, dv, any, pr);
    wrEn = 1;
    @(negedge clk);
    wrEn = 0;
    commitModel();
  endtask

  task automatic clearTable();
    for (int i = 0; i < 16; i++) writeRule(i, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic lookup(input string req, input logic [31:0] sIp, input logic [31:0] dIp,
                        input int sP, input int dP, input int pr);
    bit eHit; int eIdx;
    model(sIp, dIp, sP, dP, pr, eHit, eIdx);
    @(negedge clk);
    hdrSrcIp = sIp; hdrDstIp = dIp; hdrSrcPort = sP[15:0]; hdrDstPort = dP[15:0];
    hdrProto = pr[7:0]; reqValid = 1;
    @(negedge clk);
    reqValid = 0;
    chk({req, " valid"}, rspValid, 1);
    chk({req, " hit"}, rspHit, eHit);
    chk({req, " idx"}, rspIdx, eIdx);
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction

  initial begin
    logic [31:0] seed = 32'h1234_5678;
    for (int i = 0; i < 16; i++) begin
      mValid[i] = 0; mSrcPfx[i] = 0; mDstPfx[i] = 0; mSrcLen[i] = 0; mDstLen[i] = 0;
      mSrcOp[i] = 0; mDstOp[i] = 0; mSrcPort[i] = 0; mDstPort[i] = 0; mAny[i] = 0; mProto[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 rspValid", rspValid, 0);
    chk("R1 rspHit", rspHit, 0);
    chk("R1 rspIdx", rspIdx, 0);
    rstN = 1;
    // R1/R9: empty table after reset, even for a header any rule could match
    lookup("R1 R9 empty table", 32'h0, 32'h0, 0, 0, 0);

    // R3: prefix length sweep on source and destination address
    for (int l = 0; l <= 33; l++) begin
      writeRule(0, 1, 32'hC0A8_1E05, l, 32'h0, 0, 0, 0, 0, 0, 1, 0);
      lookup("R3 src exact", 32'hC0A8_1E05, 32'h5, 1, 1, 1);
      for (int b = 0; b < 32; b++)
        lookup("R3 src flip", 32'hC0A8_1E05 ^ (32'h1 << b), 32'h5, 1, 1, 1);
    end
    for (int l = 0; l <= 33; l += 3) begin
      writeRule(0, 1, 32'h0, 0, 32'h0A01_0203, l, 0, 0, 0, 0, 1, 0);
      for (int b = 0; b < 32; b += 5)
        lookup("R3 dst flip", 32'h7, 32'h0A01_0203 ^ (32'h1 << b), 1, 1, 1);
    end

    // R4: port operations on both port fields
    begin
      int probe [5] = '{0, 99, 100, 101, 65535};
      for (int op = 0; op < 4; op++) begin
        writeRule(0, 1, 0, 0, 0, 0, op, 100, 0, 0, 1, 0);
        foreach (probe[p]) lookup("R4 src port", 1, 1, probe[p], 5, 6);
        writeRule(0, 1, 0, 0, 0, 0, 0, 0, op, 100, 1, 0);
        foreach (probe[p]) lookup("R4 dst port", 1, 1, 5, probe[p], 6);
      end
    end

    // R5: protocol exact and free
    writeRule(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 17);
    lookup("R5 proto equal", 1, 1, 1, 1, 17);
    lookup("R5 proto differ", 1, 1, 1, 1, 6);
    writeRule(0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 17);
    lookup("R5 proto free", 1, 1, 1, 1, 6);

    // R6: every field must match
    writeRule(0, 1, 32'h0A00_0000, 8, 32'hAC10_0000, 12, 1, 80, 2, 1023, 0, 6);
    lookup("R6 all match", 32'h0A01_0101, 32'hAC1F_0001, 80, 2000, 6);
    lookup("R6 src miss", 32'h0B01_0101, 32'hAC1F_0001, 80, 2000, 6);
    lookup("R6 dst miss", 32'h0A01_0101, 32'hAC20_0001, 80, 2000, 6);
    lookup("R6 sport miss", 32'h0A01_0101, 32'hAC1F_0001, 81, 2000, 6);
    lookup("R6 dport miss", 32'h0A01_0101, 32'hAC1F_0001, 80, 1023, 6);
    lookup("R6 proto miss", 32'h0A01_0101, 32'hAC1F_0001, 80, 2000, 17);

    // R7, R8: priority and valid gating
    clearTable();
    writeRule(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    writeRule(3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    writeRule(7, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    writeRule(15, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    lookup("R7 R8 lowest of 3,7,15", 1, 2, 3, 4, 5);
    chk("R8 expect slot 3", rspIdx, 3);
    writeRule(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    lookup("R7 R8 after invalidating 3", 1, 2, 3, 4, 5);
    chk("R8 expect slot 7", rspIdx, 7);
    writeRule(7, 1, 0, 0, 0, 0, 3, 0, 0, 0, 1, 0);
    lookup("R4 R8 reserved op falls to 15", 1, 2, 3, 4, 5);
    chk("R8 expect slot 15", rspIdx, 15);
    writeRule(15, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    lookup("R9 nothing valid", 1, 2, 3, 4, 5);

    // R11: result holds without request
    writeRule(9, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    lookup("R11 setup", 1, 2, 3, 4, 5);
    @(negedge clk);
    hdrSrcIp = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R11 rspValid low", rspValid, 0);
    chk("R11 hit held", rspHit, 1);
    chk("R11 idx held", rspIdx, 9);

    // R10: write in the same cycle as a request
    clearTable();
    @(negedge clk);
    setWr(5, 1, 0, 0, 0, 0, 1, 443, 0, 0, 1, 0);
    wrEn = 1;
    hdrSrcIp = 1; hdrDstIp = 1; hdrSrcPort = 443; hdrDstPort = 1; hdrProto = 6; reqValid = 1;
    @(negedge clk);
    wrEn = 0; reqValid = 0;
    chk("R10 same cycle valid", rspValid, 1);
    chk("R10 same cycle no hit", rspHit, 0);
    chk("R10 same cycle idx", rspIdx, 0);
    commitModel();
    lookup("R10 next request sees rule", 1, 1, 443, 1, 6);
    chk("R10 slot 5", rspIdx, 5);

    // R3..R8: pseudo-random rule rewrites and headers from small value sets
    for (int n = 0; n < 3000; n++) begin
      int lens [7] = '{0, 8, 16, 24, 30, 32, 33};
      logic [31:0] a, b;
      seed = xs(seed); a = seed;
      seed = xs(seed); b = seed;
      writeRule(a[3:0], a[4], 32'h0A00_0000 | (a & 32'h0003_0003), lens[a[7:5] % 7],
                32'h0A00_0000 | (b & 32'h0003_0003), lens[b[7:5] % 7], a[9:8], a[12:10],
                b[9:8], b[12:10], a[13], a[14] ? 6 : 17);
      seed = xs(seed); a = seed;
      seed = xs(seed); b = seed;
      lookup("R6 R8 random", 32'h0A00_0000 | (a & 32'h0003_0003),
             32'h0A00_0000 | (b & 32'h0003_0003), a[10:8], b[10:8], a[20] ? 6 : 17);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule